// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside the command logic of a synchronous DRAM controller. It holds the programmable mode word and produces the column address for each beat of a read or write burst. Software-visible loading is out of its scope. Its only inputs are a load strobe with a 12-bit word, and a start pulse with an 8-bit starting column and a read/write flag.

After a start, the sequencer issues one column per clock. Each column comes with a valid flag, and the final beat also raises a last flag. Columns follow either a sequential or an interleaved order and always wrap inside the aligned block picked by the burst length. A full-page sequential burst covers the whole row and runs until an external terminate input stops it. The decoded CAS latency and the single-write setting are driven out for the data-path timing logic.

The burst settings are captured at the start pulse. A mode load during a burst therefore does not change the burst in progress. A new start pulse at any time restarts the sequence.

Top module: `colseq_top`

## Requirements
- R1: After synchronous reset the stored mode is sequential order, burst length 1, CAS latency 2 and write bursts enabled. `beat_vld`, `beat_last` and `mode_err` are 0 and `cas_lat` reads 2.
- R2: A load with word bit 11 set is ignored entirely: no stored field changes and `mode_err` stays 0.
- R3: Word bits 2..0 give the length: 000 is 1, 001 is 2, 010 is 4, 011 is 8, and 111 is full page, which is legal only with sequential order. Codes 100, 101 and 110 are reserved, and so is 111 with interleaved order. A reserved length keeps the old length and order, and `mode_err` is 1 for exactly the one cycle after the load.
- R4: Word bits 6..4 give CAS latency: 010 makes `cas_lat` 2 and 011 makes it 3. Any other code keeps the old latency and pulses `mode_err` for one cycle.
- R5: Word bit 9 set makes a burst started with `start_wr`=1 a single beat with `beat_last`, while read bursts keep the programmed length. Bit 9 clear lets writes burst as well.
- R6: In the cycle after `start`, `beat_vld` is 1 and `col_addr` equals `start_col`. Each following cycle issues the next beat.
- R7: Word bit 3 = 0 selects sequential order. For lengths 2, 4 and 8, beat k is the start column with its low log2(length) bits replaced by (start + k) modulo length. `beat_last` is 1 on beat length-1 only, and `beat_vld` drops the cycle after it.
- R8: Word bit 3 = 1 selects interleaved order: beat k is the start column XOR k (start 5 with length 8 gives 5,4,7,6,1,0,3,2).
- R9: In full-page mode beat k is (start + k) modulo 256. `beat_last` never rises, and a `term` pulse makes `beat_vld` 0 from the following cycle on.
- R10: With length 1 the order bit is ignored: a single beat at `start_col` is issued with `beat_last` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word |
| start | input | 1 | Begin a burst |
| start_col | input | 8 | Starting column |
| start_wr | input | 1 | 1 when the burst being started is a write |
| term | input | 1 | Stop the current burst |
| col_addr | output | 8 | Column of the current beat |
| beat_vld | output | 1 | A beat is issued this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| single_wr | output | 1 | Writes are single-beat |
| mode_err | output | 1 | One-cycle flag after a load with a reserved code |

## Verification
A wrongly stored length or order field shows on the first burst after the load. There the column order goes wrong by the second beat, or `beat_last` comes early or late. A wrong beat counter or block mask shows as a column that crosses the aligned block at the first wrap, which is at most eight cycles into a burst. Full-page bursts across column 255 expose a faulty modulo. Reserved and ignored loads are checked on `mode_err` one cycle later and on the next burst and `cas_lat`.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  localparam int MODE_W   = 12;
  localparam int LEN_LSB  = 0;
  localparam int ORD_BIT  = 3;
  localparam int CAS_LSB  = 4;
  localparam int WSB_BIT  = 9;
  localparam int SEL_BIT  = 11;

  localparam logic [2:0] LEN_1  = 3'b000;
  localparam logic [2:0] LEN_2  = 3'b001;
  localparam logic [2:0] LEN_4  = 3'b010;
  localparam logic [2:0] LEN_8  = 3'b011;
  localparam logic [2:0] LEN_FP = 3'b111;
  localparam logic [2:0] CAS_2  = 3'b010;
  localparam logic [2:0] CAS_3  = 3'b011;

  function automatic logic len_ok(input logic [2:0] code, input logic ilv);
    case (code)
      LEN_1, LEN_2, LEN_4, LEN_8: len_ok = 1'b1;
      LEN_FP:                     len_ok = !ilv;
      default:                    len_ok = 1'b0;
    endcase
  endfunction

  function automatic logic cas_ok(input logic [2:0] code);
    cas_ok = (code == CAS_2) || (code == CAS_3);
  endfunction
endpackage

// File: rtl/colseq_mode.sv
module colseq_mode
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld,
  input  logic [MODE_W-1:0]   word,
  output logic [COL_W-1:0]    blk_mask,
  output logic                full_pg,
  output logic                ilv,
  output logic                wr_single,
  output logic [1:0]          cas_lat,
  output logic                err
);
  logic [2:0] len_q;
  logic [2:0] cas_q;
  logic       ilv_q;
  logic       wsb_q;
  logic       take, lok, cok;

  always_comb begin
    take = ld && !word[SEL_BIT];
    lok  = len_ok(word[LEN_LSB +: 3], word[ORD_BIT]);
    cok  = cas_ok(word[CAS_LSB +: 3]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_1;
      ilv_q <= 1'b0;
      cas_q <= CAS_2;
      wsb_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      if (take) begin
        if (lok) begin
          len_q <= word[LEN_LSB +: 3];
          ilv_q <= word[ORD_BIT];
        end
        if (cok) cas_q <= word[CAS_LSB +: 3];
        wsb_q <= word[WSB_BIT];
        err   <= !(lok && cok);
      end
    end
  end

  always_comb begin
    case (len_q)
      LEN_1:   blk_mask = '0;
      LEN_2:   blk_mask = COL_W'(1);
      LEN_4:   blk_mask = COL_W'(3);
      LEN_8:   blk_mask = COL_W'(7);
      default: blk_mask = '1;
    endcase
    full_pg   = (len_q == LEN_FP);
    ilv       = ilv_q;
    wr_single = wsb_q;
    cas_lat   = cas_q[1:0];
  end

  assert_ignore_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (ld && word[SEL_BIT]) |=> ($stable(len_q) && $stable(cas_q) && $stable(wsb_q) && $stable(ilv_q) && !err));

  assert_bad_len_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !lok) |=> ($stable(len_q) && $stable(ilv_q)));

  assert_bad_cas_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (take && !cok) |=> $stable(cas_lat));

  assert_err_after_load_R3: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(take));

  assert_no_ilv_fullpage_R3: assert property (@(posedge clk) disable iff (rst)
    !(full_pg && ilv_q));
endmodule

// File: rtl/colseq_walk.sv
module colseq_walk #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             term,
  input  logic [COL_W-1:0] blk_mask,
  input  logic             full_pg,
  input  logic             ilv,
  input  logic             wr_single,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_vld,
  output logic             beat_last
);
  logic [COL_W-1:0] base_q, mask_q, cnt_q, nxt_col;
  logic             ilv_q, fp_q;
  logic             one_beat;

  always_comb begin
    one_beat = start_wr && wr_single;
    if (ilv_q) nxt_col = base_q ^ cnt_q;
    else       nxt_col = (base_q & ~mask_q) | ((base_q + cnt_q) & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mask_q    <= '0;
      cnt_q     <= '0;
      ilv_q     <= 1'b0;
      fp_q      <= 1'b0;
      col_addr  <= '0;
      beat_vld  <= 1'b0;
      beat_last <= 1'b0;
    end else if (start) begin
      base_q    <= start_col;
      mask_q    <= one_beat ? '0 : blk_mask;
      fp_q      <= full_pg && !one_beat;
      ilv_q     <= ilv;
      cnt_q     <= COL_W'(1);
      col_addr  <= start_col;
      beat_vld  <= 1'b1;
      beat_last <= one_beat || (blk_mask == '0);
    end else if (term || beat_last) begin
      beat_vld  <= 1'b0;
      beat_last <= 1'b0;
    end else if (beat_vld) begin
      col_addr  <= nxt_col;
      beat_last <= !fp_q && (cnt_q == mask_q);
      cnt_q     <= cnt_q + COL_W'(1);
    end
  end

  assert_start_col_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (beat_vld && col_addr == $past(start_col)));

  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_vld);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !start) |=> !beat_vld);

  assert_fullpage_no_last_R9: assert property (@(posedge clk) disable iff (rst)
    (beat_vld && fp_q) |-> !beat_last);

  assert_term_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (term && !start) |=> !beat_vld);

  assert_single_write_R5: assert property (@(posedge clk) disable iff (rst)
    (start && start_wr && wr_single) |=> beat_last);
endmodule

// File: rtl/colseq_top.sv
module colseq_top
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              term,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_vld,
  output logic              beat_last,
  output logic [1:0]        cas_lat,
  output logic              single_wr,
  output logic              mode_err
);
  logic [COL_W-1:0] blk_mask;
  logic             full_pg, ilv;

  colseq_mode #(.COL_W(COL_W)) mode_i (
    .clk(clk), .rst(rst), .ld(mode_ld), .word(mode_word),
    .blk_mask(blk_mask), .full_pg(full_pg), .ilv(ilv),
    .wr_single(single_wr), .cas_lat(cas_lat), .err(mode_err)
  );

  colseq_walk #(.COL_W(COL_W)) walk_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .start_wr(start_wr), .term(term), .blk_mask(blk_mask),
    .full_pg(full_pg), .ilv(ilv), .wr_single(single_wr),
    .col_addr(col_addr), .beat_vld(beat_vld), .beat_last(beat_last)
  );

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> $past(mode_ld));
endmodule

// File: tb/colseq_top_tb_top.sv
module colseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_ld, start, start_wr, term;
  logic [11:0] mode_word;
  logic [7:0]  start_col;
  logic [7:0]  col_addr;
  logic        beat_vld, beat_last, single_wr, mode_err;
  logic [1:0]  cas_lat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0] m_len;
  logic       m_ilv;
  logic [2:0] m_cas;
  logic       m_wsb;

  always #4 clk = ~clk;

  colseq_top dut_i (
    .clk(clk), .rst(rst), .mode_ld(mode_ld), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_wr(start_wr), .term(term),
    .col_addr(col_addr), .beat_vld(beat_vld), .beat_last(beat_last),
    .cas_lat(cas_lat), .single_wr(single_wr), .mode_err(mode_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic m_len_ok(input logic [2:0] c, input logic i);
    if (c <= 3'b011) return 1'b1;
    if (c == 3'b111) return !i;
    return 1'b0;
  endfunction

  function automatic logic [7:0] mask_of(input logic [2:0] c);
    case (c)
      3'b000: return 8'h00;
      3'b001: return 8'h01;
      3'b010: return 8'h03;
      3'b011: return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k, input logic [7:0] m, input logic i);
    logic [7:0] kk = 8'(k);
    if (i) return s ^ kk;
    return (s & ~m) | ((s + kk) & m);
  endfunction

  // load a word and check the error flag and latency (R2, R3, R4)
  task automatic load(input logic [11:0] w);
    logic bad;
    bad = 1'b0;
    @(negedge clk);
    mode_ld = 1'b1; mode_word = w;
    @(negedge clk);
    mode_ld = 1'b0;
    if (!w[11]) begin
      if (m_len_ok(w[2:0], w[3])) begin m_len = w[2:0]; m_ilv = w[3]; end
      else bad = 1'b1;
      if (w[6:4] == 3'b010 || w[6:4] == 3'b011) m_cas = w[6:4];
      else bad = 1'b1;
      m_wsb = w[9];
      chk(bad ? "R3/R4" : "R3", "mode_err after load", mode_err, bad);
    end else begin
      chk("R2", "mode_err after ignored load", mode_err, 1'b0);
    end
    chk("R4", "cas_lat", cas_lat, m_cas[1:0]);
    chk("R5", "single_wr", single_wr, m_wsb);
    @(negedge clk);
    chk("R3", "mode_err one cycle", mode_err, 1'b0);
  endtask

  // run a burst and check every beat (R5..R10)
  task automatic burst(input logic [7:0] s, input logic wr, input int tlen, input string req);
    logic [7:0] m;
    logic       fp;
    int         n;
    m  = (wr && m_wsb) ? 8'h00 : mask_of(m_len);
    fp = (m_len == 3'b111) && !(wr && m_wsb);
    n  = fp ? tlen : int'(m) + 1;
    start = 1'b1; start_col = s; start_wr = wr;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0; term = 1'b0;
      chk(req, "beat_vld", beat_vld, 1'b1);
      chk(req, "col_addr", col_addr, fp ? 8'(s + 8'(k)) : exp_col(s, k, m, m_ilv));
      chk(req, "beat_last", beat_last, (!fp && k == n - 1));
      if (fp && k == n - 1) term = 1'b1;
    end
    @(negedge clk);
    term = 1'b0;
    chk(req, "idle after burst", beat_vld, 1'b0);
  endtask

  function automatic logic [11:0] mk(input logic wsb, input logic [2:0] cas, input logic i, input logic [2:0] len);
    return {1'b0, 1'b0, wsb, 2'b00, cas, i, len};
  endfunction

  initial begin
    int sd;
    logic [11:0] w;
    sd = $urandom(32'd7321);
    rst = 1'b1; mode_ld = 0; mode_word = 0; start = 0; start_col = 0; start_wr = 0; term = 0;
    m_len = 3'b000; m_ilv = 0; m_cas = 3'b010; m_wsb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset beat_vld", beat_vld, 1'b0);
    chk("R1", "reset beat_last", beat_last, 1'b0);
    chk("R1", "reset mode_err", mode_err, 1'b0);
    chk("R1", "reset cas_lat", cas_lat, 2'd2);
    chk("R1", "reset single_wr", single_wr, 1'b0);
    burst(8'h3A, 1'b1, 0, "R1");

    load(mk(0, 3'b011, 0, 3'b011));
    burst(8'h05, 1'b0, 0, "R7");
    load(mk(0, 3'b011, 1, 3'b011));
    burst(8'h05, 1'b0, 0, "R8");
    load(mk(0, 3'b010, 0, 3'b010));
    burst(8'h06, 1'b0, 0, "R7");
    load(mk(0, 3'b010, 1, 3'b000));
    burst(8'hC7, 1'b0, 0, "R10");
    load(mk(0, 3'b011, 0, 3'b111));
    burst(8'hFA, 1'b0, 10, "R9");
    load(mk(0, 3'b011, 1, 3'b111));
    burst(8'hFE, 1'b0, 4, "R3");
    load(mk(0, 3'b101, 0, 3'b010));
    load(mk(0, 3'b010, 0, 3'b110));
    burst(8'h11, 1'b0, 0, "R3");
    load(12'h800 | mk(1, 3'b011, 1, 3'b001));
    burst(8'h22, 1'b1, 0, "R2");
    load(mk(1, 3'b011, 0, 3'b011));
    burst(8'h44, 1'b1, 0, "R5");
    burst(8'h44, 1'b0, 0, "R5");

    for (int it = 0; it < 300; it++) begin
      w = 12'($urandom);
      w[11] = ($urandom % 8 == 0);
      w[10] = 1'b0;
      if ($urandom % 4 != 0) w[6:4] = 3'b010 + 3'($urandom % 2);
      if ($urandom % 4 != 0) w[2:0] = 3'($urandom % 4);
      load(w);
      burst(8'($urandom), 1'($urandom), 1 + int'($urandom % 40), "R7/R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule